// File: doc/BRIEF.md
# T1 Facility Data Link Transmitter

This block turns a byte written by the host into a serial stream of overhead bits for an outgoing T1 signal. The framer raises a slot strobe at each overhead bit time. In extended-superframe mode these are the data link bits, and in superframe (D4) mode they are the Fs framing bits. At each strobe the block puts the next bit of the current byte on its serial output, least significant bit first. The output is registered, so each bit shows up one clock after its strobe.

Host writes go into a holding register. That register is copied into the shift register only when a byte finishes. At that moment a latched empty flag goes up to ask for the next byte. If the host sends nothing new in time, the held byte simply goes out again. An active-low interrupt follows the flag whenever the mask bit allows it.

In D4 mode only the low six bits are used, and the byte is realigned to the multiframe start strobe. Holding the value 1Ch yields the standard Fs framing pattern, and it is the reset value. While insertion is disabled, the slots carry an alternate bit supplied from outside.

Top module: `fdl_tx_top`

## Requirements
- R1: After reset ser_bit is 0, empty_flag is 0 and irq_n is 1. The holding register contains RESET_BYTE (default 8'h1C).
- R2: While ins_en=1 and mode_d4=0, each slot_stb sends one bit of the current byte on ser_bit, starting at bit 0 and ending at bit 7. The bit appears in the cycle after the strobe. ser_bit does not change in cycles without a strobe.
- R3: When mode_d4=1, a byte is six strobes long and carries bits 0 to 5. Bits 7:6 are ignored, so 8'h1C and 8'hDC both produce 0,0,1,1,1,0.
- R4: When mode_d4=1, a slot_stb that arrives together with mf_start always sends bit 0 and restarts the byte from there.
- R5: In the cycle after the strobe that carries the last bit of a byte, empty_flag reads 1.
- R6: empty_flag stays at 1 until empty_clr is pulsed. If a byte ends in the same cycle as a clear, the flag stays set.
- R7: irq_n is 0 exactly when empty_flag is 1 and irq_mask is 1. It is updated on the same clock edge as empty_flag.
- R8: If nothing is written during a byte, the next byte sent is identical to it.
- R9: A write that arrives in the middle of a byte has no effect on that byte. The new value goes out starting with the next byte.
- R10: While ins_en=0, each slot_stb copies alt_bit to ser_bit and empty_flag never sets. Once ins_en goes back to 1, sending begins at bit 0 of the held byte.
- R11: No zero stuffing is applied. A byte of 8'hFF produces eight consecutive ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr_en | input | 1 | Write strobe for the holding register |
| host_wr_data | input | 8 | Byte to transmit |
| ins_en | input | 1 | 1: insert the held byte; 0: pass alt_bit through |
| mode_d4 | input | 1 | 0: extended superframe (8 bits per byte); 1: D4 (6 bits per byte) |
| empty_clr | input | 1 | Write-one-to-clear pulse for empty_flag |
| irq_mask | input | 1 | 1 lets empty_flag drive the interrupt |
| slot_stb | input | 1 | Marks one overhead bit time |
| mf_start | input | 1 | Multiframe start; only takes effect together with slot_stb |
| alt_bit | input | 1 | Overhead bit used while insertion is disabled |
| ser_bit | output | 1 | Serial overhead bit, registered |
| empty_flag | output | 1 | Latched request for a new byte |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The bench uses the default parameters: an 8-bit byte, a 6-bit D4 byte and a reset byte of 1Ch. Because of that reset value, the D4 framing pattern can be checked before the host has written anything. The 6-of-8 split means a late multiframe strobe can be distinguished from plain counting, since bit 0 and bit 3 of 1Ch differ. An all-ones byte in extended-superframe mode runs past five ones, which exposes any inserted stuffing zero.

// File: rtl/fdl_tx_pkg.sv
package fdl_tx_pkg;
  typedef enum logic {
    FRM_ESF = 1'b0,
    FRM_D4  = 1'b1
  } frm_mode_e;
endpackage

// File: rtl/fdl_hold_reg.sv
module fdl_hold_reg #(
  parameter int BYTE_W = 8,
  parameter logic [BYTE_W-1:0] RESET_BYTE = 8'h1C
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [BYTE_W-1:0] hold
);
  always_ff @(posedge clk) begin
    if (rst) hold <= RESET_BYTE;
    else if (wr_en) hold <= wr_data;
  end

  // R8: the held value only changes on a write
  p_hold_kept_r8: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(hold));
endmodule

// File: rtl/fdl_bit_sequencer.sv
module fdl_bit_sequencer
  import fdl_tx_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int D4_BITS = 6,
  parameter logic [BYTE_W-1:0] RESET_BYTE = 8'h1C
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ins_en,
  input  frm_mode_e         mode,
  input  logic              slot_stb,
  input  logic              mf_start,
  input  logic              alt_bit,
  input  logic [BYTE_W-1:0] hold,
  output logic              ser_bit,
  output logic              byte_done
);
  localparam int POS_W = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
  localparam logic [POS_W-1:0] ESF_LAST = POS_W'(BYTE_W - 1);
  localparam logic [POS_W-1:0] D4_LAST  = POS_W'(D4_BITS - 1);

  logic [BYTE_W-1:0] shreg;
  logic [POS_W-1:0]  pos, pos_eff, last_pos;
  logic              realign, bit_now, at_end;

  always_comb begin
    last_pos  = (mode == FRM_D4) ? D4_LAST : ESF_LAST;
    realign   = (mode == FRM_D4) && mf_start;
    pos_eff   = realign ? '0 : pos;
    bit_now   = shreg[pos_eff];
    at_end    = (pos_eff >= last_pos);
    byte_done = ins_en && slot_stb && at_end;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg   <= RESET_BYTE;
      pos     <= '0;
      ser_bit <= 1'b0;
    end else if (!ins_en) begin
      shreg <= hold;
      pos   <= '0;
      if (slot_stb) ser_bit <= alt_bit;
    end else if (slot_stb) begin
      ser_bit <= bit_now;
      if (at_end) begin
        shreg <= hold;
        pos   <= '0;
      end else begin
        pos <= pos_eff + POS_W'(1);
      end
    end
  end

  // R2: the output only moves on a slot strobe
  p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !slot_stb |=> $stable(ser_bit));
  // R9: the byte in flight is never replaced before its end
  p_byte_intact_r9: assert property (@(posedge clk) disable iff (rst)
    ins_en && !byte_done |=> $stable(shreg));
  // R10: pass-through of the alternate source while disabled
  p_alt_pass_r10: assert property (@(posedge clk) disable iff (rst)
    !ins_en && slot_stb |=> ser_bit == $past(alt_bit));
  // R4: a multiframe strobe in D4 mode sends bit 0 of the byte
  p_realign_r4: assert property (@(posedge clk) disable iff (rst)
    ins_en && slot_stb && mode == FRM_D4 && mf_start |=> ser_bit == $past(shreg[0]));
endmodule

// File: rtl/fdl_empty_irq.sv
module fdl_empty_irq (
  input  logic clk,
  input  logic rst,
  input  logic set_evt,
  input  logic clr,
  input  logic mask,
  output logic empty_flag,
  output logic irq_n
);
  logic flag_d;

  always_comb flag_d = set_evt | (empty_flag & ~clr);

  always_ff @(posedge clk) begin
    if (rst) begin
      empty_flag <= 1'b0;
      irq_n      <= 1'b1;
    end else begin
      empty_flag <= flag_d;
      irq_n      <= ~(flag_d & mask);
    end
  end

  p_set_wins_r6: assert property (@(posedge clk) disable iff (rst)
    set_evt |=> empty_flag);
  p_flag_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    empty_flag && !clr |=> empty_flag);
  p_flag_clears_r6: assert property (@(posedge clk) disable iff (rst)
    clr && !set_evt |=> !empty_flag);
  p_irq_match_r7: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> irq_n == !(empty_flag && $past(mask)));
endmodule

// File: rtl/fdl_tx_top.sv
module fdl_tx_top
  import fdl_tx_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int D4_BITS = 6,
  parameter logic [BYTE_W-1:0] RESET_BYTE = 8'h1C
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_wr_en,
  input  logic [BYTE_W-1:0] host_wr_data,
  input  logic              ins_en,
  input  logic              mode_d4,
  input  logic              empty_clr,
  input  logic              irq_mask,
  input  logic              slot_stb,
  input  logic              mf_start,
  input  logic              alt_bit,
  output logic              ser_bit,
  output logic              empty_flag,
  output logic              irq_n
);
  logic [BYTE_W-1:0] hold;
  logic              byte_done;
  frm_mode_e         mode;

  assign mode = mode_d4 ? FRM_D4 : FRM_ESF;

  fdl_hold_reg #(.BYTE_W(BYTE_W), .RESET_BYTE(RESET_BYTE)) u_hold (
    .clk(clk), .rst(rst), .wr_en(host_wr_en), .wr_data(host_wr_data), .hold(hold)
  );

  fdl_bit_sequencer #(.BYTE_W(BYTE_W), .D4_BITS(D4_BITS), .RESET_BYTE(RESET_BYTE)) u_seq (
    .clk(clk), .rst(rst), .ins_en(ins_en), .mode(mode), .slot_stb(slot_stb),
    .mf_start(mf_start), .alt_bit(alt_bit), .hold(hold),
    .ser_bit(ser_bit), .byte_done(byte_done)
  );

  fdl_empty_irq u_irq (
    .clk(clk), .rst(rst), .set_evt(byte_done), .clr(empty_clr), .mask(irq_mask),
    .empty_flag(empty_flag), .irq_n(irq_n)
  );

  // R10: no byte completes while insertion is off
  p_no_set_disabled_r10: assert property (@(posedge clk) disable iff (rst)
    !ins_en && !empty_flag && !$past(empty_flag) |-> !byte_done);
endmodule

// File: tb/tb_fdl_tx_top.sv
module tb_fdl_tx_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic host_wr_en = 1'b0;
  logic [7:0] host_wr_data = 8'h00;
  logic ins_en = 1'b0, mode_d4 = 1'b0, empty_clr = 1'b0, irq_mask = 1'b0;
  logic slot_stb = 1'b0, mf_start = 1'b0, alt_bit = 1'b0;
  logic ser_bit, empty_flag, irq_n;
  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  fdl_tx_top dut (
    .clk(clk), .rst(rst), .host_wr_en(host_wr_en), .host_wr_data(host_wr_data),
    .ins_en(ins_en), .mode_d4(mode_d4), .empty_clr(empty_clr), .irq_mask(irq_mask),
    .slot_stb(slot_stb), .mf_start(mf_start), .alt_bit(alt_bit),
    .ser_bit(ser_bit), .empty_flag(empty_flag), .irq_n(irq_n)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic strobe(input bit mf, input bit alt, input bit clr, output bit b);
    @(negedge clk);
    slot_stb = 1'b1; mf_start = mf; alt_bit = alt; empty_clr = clr;
    @(negedge clk);
    slot_stb = 1'b0; mf_start = 1'b0; empty_clr = 1'b0;
    b = ser_bit;
  endtask

  task automatic host_write(input logic [7:0] v);
    @(negedge clk); host_wr_en = 1'b1; host_wr_data = v;
    @(negedge clk); host_wr_en = 1'b0;
  endtask

  task automatic clear_flag();
    @(negedge clk); empty_clr = 1'b1;
    @(negedge clk); empty_clr = 1'b0;
  endtask

  // sends bits lo..hi of v, mf on first when requested, checks each
  task automatic send_bits(input logic [7:0] v, input int lo, input int hi,
                           input bit mf_first, input string tag);
    bit b;
    for (int i = lo; i <= hi; i++) begin
      strobe(mf_first && (i == lo), 1'b0, 1'b0, b);
      chk(b == v[i], tag, b, v[i]);
    end
  endtask

  task automatic t_reset();
    chk(ser_bit == 1'b0, "R1 ser_bit", ser_bit, 0);
    chk(empty_flag == 1'b0, "R1 empty_flag", empty_flag, 0);
    chk(irq_n == 1'b1, "R1 irq_n", irq_n, 1);
  endtask

  task automatic t_disabled();
    bit b;
    ins_en = 1'b0;
    for (int i = 0; i < 4; i++) begin
      strobe(1'b0, i[0] ^ 1'b1, 1'b0, b);
      chk(b == (i[0] ^ 1'b1), "R10 alt pass", b, i[0] ^ 1'b1);
    end
    chk(empty_flag == 1'b0, "R10 no flag", empty_flag, 0);
  endtask

  task automatic t_d4();
    bit b;
    @(negedge clk); mode_d4 = 1'b1; ins_en = 1'b1;
    // reset byte 1Ch, low six bits
    send_bits(8'h1C, 0, 4, 1'b1, "R1/R3 d4 pattern");
    chk(empty_flag == 1'b0, "R5 d4 before end", empty_flag, 0);
    send_bits(8'h1C, 5, 5, 1'b0, "R3 d4 bit5");
    chk(empty_flag == 1'b1, "R5 d4 flag", empty_flag, 1);
    clear_flag();
    chk(empty_flag == 1'b0, "R6 clear", empty_flag, 0);
    host_write(8'hDC);
    send_bits(8'h1C, 0, 5, 1'b1, "R3 d4 second");
    clear_flag();
    send_bits(8'hDC, 0, 5, 1'b1, "R3 upper ignored");
    chk(empty_flag == 1'b1, "R3 six-bit byte", empty_flag, 1);
    clear_flag();
    // R4: three bits then a multiframe strobe restarts at bit 0
    send_bits(8'hDC, 0, 2, 1'b1, "R4 pre");
    strobe(1'b1, 1'b0, 1'b0, b);
    chk(b == 1'b0, "R4 realign bit0", b, 0);
    send_bits(8'hDC, 1, 2, 1'b0, "R4 after realign");
    chk(empty_flag == 1'b0, "R4 no early end", empty_flag, 0);
  endtask

  task automatic t_esf();
    @(negedge clk); ins_en = 1'b0; mode_d4 = 1'b0; irq_mask = 1'b0;
    host_write(8'hA5);
    clear_flag();
    @(negedge clk); ins_en = 1'b1;
    send_bits(8'hA5, 0, 6, 1'b0, "R2/R10 esf lsb first");
    chk(empty_flag == 1'b0, "R5 before last", empty_flag, 0);
    send_bits(8'hA5, 7, 7, 1'b0, "R2 bit7");
    chk(empty_flag == 1'b1, "R5 esf flag", empty_flag, 1);
    chk(irq_n == 1'b1, "R7 masked", irq_n, 1);
    @(negedge clk); irq_mask = 1'b1;
    @(negedge clk);
    chk(irq_n == 1'b0, "R7 irq low", irq_n, 0);
    repeat (3) @(negedge clk);
    chk(empty_flag == 1'b1, "R6 sticky", empty_flag, 1);
    clear_flag();
    chk(irq_n == 1'b1, "R7 irq released", irq_n, 1);
    send_bits(8'hA5, 0, 7, 1'b0, "R8 repeat");
    send_bits(8'hA5, 0, 2, 1'b0, "R9 pre");
    host_write(8'h3C);
    send_bits(8'hA5, 3, 7, 1'b0, "R9 old byte intact");
    send_bits(8'h3C, 0, 1, 1'b0, "R9 new byte");
    host_write(8'hFF);
    send_bits(8'h3C, 2, 7, 1'b0, "R9 new byte tail");
    send_bits(8'hFF, 0, 7, 1'b0, "R11 eight ones");
  endtask

  task automatic t_set_wins();
    bit b;
    clear_flag();
    send_bits(8'hFF, 0, 6, 1'b0, "R11 ones again");
    strobe(1'b0, 1'b0, 1'b1, b);
    chk(empty_flag == 1'b1, "R6 set wins", empty_flag, 1);
    clear_flag();
    chk(empty_flag == 1'b0, "R6 cleared", empty_flag, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_disabled();
    t_d4();
    t_esf();
    t_set_wins();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule